// File: doc/BRIEF.md
# Duty-Cycled Supply Monitor Controller

This block is the digital sequencer that sits beside three analog supply comparators. The comparators flag a supply below a programmable warning level, below the brown-out reset level, and below the power-on level. The block switches them on, samples their settled outputs and turns the results into a sticky warning interrupt and an active-high internal reset request. To save power, the comparators can run in short periodic windows instead of continuously, and they can be shut down completely while the device sleeps in stop mode.

Software uses a single 7-bit control write. Bits [1:0] select the warning level code, which goes to the analog reference (00 = 1.8 V, 01 = 1.9 V, 10 = 2.55 V, 11 = 2.75 V). Bit [2] disables monitoring during stop mode. Bits [4:3] select the sampling interval. Bit [5] enables the interrupt. Writing 1 to bit [6] clears the warning flag.

When the system wants to leave stop mode, it raises a wake request. The block then runs one sampling window and reports that the wake may proceed. Any pending warning is therefore flagged, and any pending brown-out becomes a reset, before code runs again.

Top module: `pfmon_ctrl`

## Requirements
- R1: `thr_code_o` equals the last accepted value of control bits [1:0]. It returns to 00 only when `por_rst_n` is low, and keeps its value through a `rst_n` reset.
- R2: A control write that arrives while the interrupt enable (bit 5) is already 1 leaves `thr_code_o` unchanged.
- R3: After `rst_n` or `por_rst_n`, the stop-disable bit (bit 2) is 1. While `stop_i`=1, that bit is 1 and `wake_req_i`=0: `mon_en_o` is 0, and no comparator input sets the warning flag or `rst_req_o`. With the bit at 0, monitoring continues during stop.
- R4: `cmp_por_i`=1 drives `rst_req_o` to 1 in the same cycle, in every mode.
- R5: Interval select (bits [4:3]) works as follows. 00 keeps `mon_en_o` at 1 continuously. 01, 10 and 11 give periods of 2^BASE_EXP, 2^(BASE_EXP+1) and 2^(BASE_EXP+2) ticks. In each period, `mon_en_o` is 1 for the first two ticks.
- R6: In periodic mode, comparators are sampled only on the tick that ends the two-tick window. Comparator levels at all other ticks have no effect.
- R7: A sample with `cmp_rst_i`=1 sets `rst_req_o` after that clock edge. It stays 1 until a later sample sees `cmp_rst_i`=0.
- R8: A sample with `cmp_warn_i`=1 sets `warn_flag_o`, which holds until a control write with bit 6 set. `irq_o` is `warn_flag_o` AND the interrupt enable.
- R9: In stop mode with monitoring disabled, `wake_req_i`=1 enables the comparators and runs one window. After that window's sample, `wake_ready_o` rises and the sample's results are recorded.
- R10: The interval counter restarts at the start of a window on every control write and on `rst_n` release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst_n | input | 1 | Power-on reset, synchronous, active low |
| rst_n | input | 1 | Other reset sources, synchronous, active low |
| tick_i | input | 1 | One-cycle pulse per slow oscillator period |
| stop_i | input | 1 | Device is in stop mode |
| wake_req_i | input | 1 | Stop exit requested |
| cmp_warn_i | input | 1 | Supply below warning level |
| cmp_rst_i | input | 1 | Supply below reset level |
| cmp_por_i | input | 1 | Supply below power-on level |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 7 | Control write data |
| mon_en_o | output | 1 | Comparator enable |
| thr_code_o | output | 2 | Warning level code |
| warn_flag_o | output | 1 | Sticky warning flag |
| irq_o | output | 1 | Warning interrupt |
| rst_req_o | output | 1 | Internal reset request, active high |
| wake_ready_o | output | 1 | Stop exit may proceed |

## Verification
The bench builds the block with BASE_EXP=3, so the periods are 8, 16 and 32 ticks instead of thousands. This brings several cases within a few hundred cycles: whole periods and window wrap-around, comparator pulses placed just outside a window, and the recovery sample that releases a held reset. It also reaches the stop-mode wake window and the threshold lock under an enabled interrupt.

// File: rtl/pfmon_pkg.sv
// Package: shared control-word layout for the supply monitor controller.
// Assumes a 7-bit control write; bit 6 is a write-one-to-clear action.
package pfmon_pkg;
    localparam int CTL_W   = 7;
    localparam int CLR_BIT = 6;

    typedef enum logic [1:0] {
        INTV_CONT  = 2'b00,
        INTV_SHORT = 2'b01,
        INTV_MID   = 2'b10,
        INTV_LONG  = 2'b11
    } intv_e;

    // Packed so bits [5:0] of the write data map straight onto it.
    typedef struct packed {
        logic       irq_en;
        intv_e      intv;
        logic       stop_dis;
        logic [1:0] thr;
    } cfg_t;
endpackage

// File: rtl/pfmon_regs.sv
// Module: control register. Holds level code, stop-disable, interval and
// interrupt enable. The level code is cleared only by power-on reset and is
// locked while the interrupt enable is set.
module pfmon_regs
    import pfmon_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst_n,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CTL_W-1:0] wdata_i,
    output cfg_t             cfg_o,
    output logic             flag_clr_o,
    output logic             restart_o
);
    cfg_t cfg_q;

    // Level code: power-on reset only, writes ignored while interrupt enabled.
    always_ff @(posedge clk) begin
        if (!por_rst_n)
            cfg_q.thr <= 2'b00;
        else if (we_i && !cfg_q.irq_en)
            cfg_q.thr <= wdata_i[1:0];
    end

    // Remaining fields: cleared by any reset source, loaded on write.
    always_ff @(posedge clk) begin
        if (!por_rst_n || !rst_n) begin
            cfg_q.stop_dis <= 1'b1;
            cfg_q.intv     <= INTV_CONT;
            cfg_q.irq_en   <= 1'b0;
        end else if (we_i) begin
            cfg_q.stop_dis <= wdata_i[2];
            cfg_q.intv     <= intv_e'(wdata_i[4:3]);
            cfg_q.irq_en   <= wdata_i[5];
        end
    end

    assign cfg_o      = cfg_q;
    assign flag_clr_o = we_i && wdata_i[CLR_BIT];
    assign restart_o  = we_i;
endmodule

// File: rtl/pfmon_sched.sv
// Module: sampling scheduler. Counts oscillator ticks over the selected
// period, opens a two-tick enable window at the start of each period and
// issues a sample strobe on the tick that closes the window.
// Assumes tick_i is a single-cycle pulse already in the clk domain.
module pfmon_sched
    import pfmon_pkg::*;
#(
    parameter int BASE_EXP = 11
) (
    input  logic  clk,
    input  logic  por_rst_n,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  hold_i,
    input  logic  restart_i,
    input  intv_e intv_i,
    output logic  mon_en_o,
    output logic  samp_o
);
    localparam int CW = BASE_EXP + 2;
    localparam logic [CW-1:0] LAST_LONG  = {CW{1'b1}};
    localparam logic [CW-1:0] LAST_MID   = LAST_LONG >> 1;
    localparam logic [CW-1:0] LAST_SHORT = LAST_LONG >> 2;
    localparam logic [CW-1:0] WIN_END    = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;
    logic          cont;

    // Pick the final count of the period for the selected interval.
    always_comb begin
        case (intv_i)
            INTV_SHORT: last_cnt = LAST_SHORT;
            INTV_MID:   last_cnt = LAST_MID;
            default:    last_cnt = LAST_LONG;
        endcase
    end

    assign cont = (intv_i == INTV_CONT);

    // Tick counter: held at zero in reset, while gated, on restart or continuous.
    always_ff @(posedge clk) begin
        if (!por_rst_n || !rst_n || hold_i || restart_i || cont)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= (cnt_q == last_cnt) ? '0 : cnt_q + 1'b1;
    end

    assign mon_en_o = !hold_i && (cont || (cnt_q <= WIN_END));
    assign samp_o   = !hold_i && tick_i && (cont || (cnt_q == WIN_END));
endmodule

// File: rtl/pfmon_eval.sv
// Module: result evaluation. Turns sampled comparator levels into a sticky
// warning flag, a held reset request and a wake-check-done marker.
// Assumes samp_o of the scheduler marks settled comparator outputs.
module pfmon_eval (
    input  logic clk,
    input  logic por_rst_n,
    input  logic rst_n,
    input  logic samp_i,
    input  logic in_stop_i,
    input  logic cmp_warn_i,
    input  logic cmp_rst_i,
    input  logic flag_clr_i,
    output logic flag_o,
    output logic rst_latch_o,
    output logic wake_done_o
);
    logic flag_q, rst_q, wake_q;

    // Sticky warning flag: set by a sample, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!por_rst_n || !rst_n)
            flag_q <= 1'b0;
        else if (samp_i && cmp_warn_i)
            flag_q <= 1'b1;
        else if (flag_clr_i)
            flag_q <= 1'b0;
    end

    // Reset latch: every sample overwrites it; survives rst_n so it can release itself.
    always_ff @(posedge clk) begin
        if (!por_rst_n)
            rst_q <= 1'b0;
        else if (samp_i)
            rst_q <= cmp_rst_i;
    end

    // Wake marker: a sample taken during stop; dropped once stop ends.
    always_ff @(posedge clk) begin
        if (!por_rst_n || !in_stop_i)
            wake_q <= 1'b0;
        else if (samp_i)
            wake_q <= 1'b1;
    end

    assign flag_o      = flag_q;
    assign rst_latch_o = rst_q;
    assign wake_done_o = wake_q;
endmodule

// File: rtl/pfmon_ctrl.sv
// Module: top of the duty-cycled supply monitor controller. Gates the
// comparators in stop mode, schedules sampling windows and reports the
// warning interrupt and internal reset request.
// Assumes all comparator and control inputs are synchronous to clk.
module pfmon_ctrl
    import pfmon_pkg::*;
#(
    parameter int BASE_EXP = 11
) (
    input  logic             clk,
    input  logic             por_rst_n,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             stop_i,
    input  logic             wake_req_i,
    input  logic             cmp_warn_i,
    input  logic             cmp_rst_i,
    input  logic             cmp_por_i,
    input  logic             ctl_we_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    output logic             mon_en_o,
    output logic [1:0]       thr_code_o,
    output logic             warn_flag_o,
    output logic             irq_o,
    output logic             rst_req_o,
    output logic             wake_ready_o
);
    cfg_t cfg;
    logic flag_clr, restart, samp, gate_off;
    logic rst_latch, wake_done;
    logic stop_dis_w, irq_en_w;

    assign stop_dis_w = cfg.stop_dis;
    assign irq_en_w   = cfg.irq_en;
    assign gate_off   = stop_i && cfg.stop_dis && !wake_req_i;

    pfmon_regs u_regs (
        .clk        (clk),
        .por_rst_n  (por_rst_n),
        .rst_n      (rst_n),
        .we_i       (ctl_we_i),
        .wdata_i    (ctl_wdata_i),
        .cfg_o      (cfg),
        .flag_clr_o (flag_clr),
        .restart_o  (restart)
    );

    pfmon_sched #(.BASE_EXP(BASE_EXP)) u_sched (
        .clk       (clk),
        .por_rst_n (por_rst_n),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .hold_i    (gate_off),
        .restart_i (restart),
        .intv_i    (cfg.intv),
        .mon_en_o  (mon_en_o),
        .samp_o    (samp)
    );

    pfmon_eval u_eval (
        .clk         (clk),
        .por_rst_n   (por_rst_n),
        .rst_n       (rst_n),
        .samp_i      (samp),
        .in_stop_i   (stop_i),
        .cmp_warn_i  (cmp_warn_i),
        .cmp_rst_i   (cmp_rst_i),
        .flag_clr_i  (flag_clr),
        .flag_o      (warn_flag_o),
        .rst_latch_o (rst_latch),
        .wake_done_o (wake_done)
    );

    assign thr_code_o   = cfg.thr;
    assign irq_o        = warn_flag_o && cfg.irq_en;
    assign rst_req_o    = rst_latch || cmp_por_i;
    assign wake_ready_o = stop_i && wake_req_i && (!cfg.stop_dis || wake_done);
endmodule

// File: rtl/pfmon_ctrl_chk.sv
// Module: property checker bound onto pfmon_ctrl.
// Assumes por_rst_n is held low from time zero for at least one edge.
module pfmon_ctrl_chk (
    input logic       clk,
    input logic       por_rst_n,
    input logic       stop_i,
    input logic       wake_req_i,
    input logic       cmp_warn_i,
    input logic       cmp_rst_i,
    input logic       cmp_por_i,
    input logic       stop_dis,
    input logic       irq_en,
    input logic       samp,
    input logic       rst_latch,
    input logic       mon_en_o,
    input logic [1:0] thr_code_o,
    input logic       warn_flag_o,
    input logic       irq_o,
    input logic       rst_req_o
);
    // R3
    gated_off_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        (stop_i && stop_dis && !wake_req_i) |-> !mon_en_o);
    // R4
    por_trip_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        cmp_por_i |-> rst_req_o);
    // R2
    thr_lock_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        $past(irq_en) |-> $stable(thr_code_o));
    // R6
    samp_window_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        samp |-> mon_en_o);
    // R7
    rst_rise_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        $rose(rst_latch) |-> $past(samp && cmp_rst_i));
    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        $rose(warn_flag_o) |-> $past(samp && cmp_warn_i));
    // R8
    irq_flag_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        irq_o |-> warn_flag_o);
endmodule

bind pfmon_ctrl pfmon_ctrl_chk u_chk (
    .clk         (clk),
    .por_rst_n   (por_rst_n),
    .stop_i      (stop_i),
    .wake_req_i  (wake_req_i),
    .cmp_warn_i  (cmp_warn_i),
    .cmp_rst_i   (cmp_rst_i),
    .cmp_por_i   (cmp_por_i),
    .stop_dis    (stop_dis_w),
    .irq_en      (irq_en_w),
    .samp        (samp),
    .rst_latch   (rst_latch),
    .mon_en_o    (mon_en_o),
    .thr_code_o  (thr_code_o),
    .warn_flag_o (warn_flag_o),
    .irq_o       (irq_o),
    .rst_req_o   (rst_req_o)
);

// File: tb/pfmon_ctrl_tb.sv
// Directed bench for pfmon_ctrl, built with BASE_EXP=3 (periods 8/16/32 ticks).
module pfmon_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       por_rst_n = 1'b0;
    logic       rst_n = 1'b1;
    logic       tick = 1'b0;
    logic       stop = 1'b0;
    logic       wake = 1'b0;
    logic       cw = 1'b0, cr = 1'b0, cp = 1'b0;
    logic       we = 1'b0;
    logic [6:0] wd = '0;
    logic       mon_en, warn_flag, irq, rst_req, wake_ready;
    logic [1:0] thr;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    pfmon_ctrl #(.BASE_EXP(3)) dut_i (
        .clk(clk), .por_rst_n(por_rst_n), .rst_n(rst_n), .tick_i(tick),
        .stop_i(stop), .wake_req_i(wake), .cmp_warn_i(cw), .cmp_rst_i(cr),
        .cmp_por_i(cp), .ctl_we_i(we), .ctl_wdata_i(wd), .mon_en_o(mon_en),
        .thr_code_o(thr), .warn_flag_o(warn_flag), .irq_o(irq),
        .rst_req_o(rst_req), .wake_ready_o(wake_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic do_write(input logic [6:0] v);
        @(negedge clk) begin we = 1'b1; wd = v; end
        @(negedge clk) we = 1'b0;
    endtask

    task automatic pulse_rst(input bit por);
        @(negedge clk) if (por) por_rst_n = 1'b0; else rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) begin por_rst_n = 1'b1; rst_n = 1'b1; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 thr after por", thr, 0);
        chk("R5 continuous after reset", mon_en, 1);
        chk("R8 flag after reset", warn_flag, 0);
        chk("R8 irq after reset", irq, 0);
        chk("R7 rst_req after reset", rst_req, 0);
        chk("R9 wake_ready idle", wake_ready, 0);
    endtask

    task automatic t_threshold();
        do_write(7'h06);                       // thr=10, stop_dis=1
        chk("R1 thr loaded", thr, 2);
        do_write(7'h26);                       // enable interrupt
        do_write(7'h27);                       // thr=11 while irq enabled
        chk("R2 thr locked", thr, 2);
        pulse_rst(1'b0);
        chk("R1 thr survives rst_n", thr, 2);
        do_write(7'h05);
        chk("R1 thr reloaded", thr, 1);
    endtask

    task automatic t_period();
        do_write(7'h0C);                       // interval 01, period 8
        for (int k = 0; k < 18; k++) begin
            chk("R5 short window", mon_en, ((k % 8) < 2) ? 1 : 0);
            do_tick(1);
        end
        do_write(7'h1C);                       // interval 11, period 32
        do_tick(2);
        chk("R5 long closed", mon_en, 0);
        do_tick(29);
        chk("R5 long still closed", mon_en, 0);
        do_tick(1);
        chk("R5 long reopened", mon_en, 1);
    endtask

    task automatic t_sample();
        do_write(7'h0C);
        do_tick(2);
        @(negedge clk) begin cw = 1'b1; cr = 1'b1; end
        do_tick(5);
        chk("R6 warn ignored outside window", warn_flag, 0);
        chk("R6 rst ignored outside window", rst_req, 0);
        @(negedge clk) begin cw = 1'b0; cr = 1'b0; end
        do_tick(2);
        @(negedge clk) begin cw = 1'b1; cr = 1'b1; end
        do_tick(1);
        chk("R7 rst set by sample", rst_req, 1);
        chk("R8 flag set by sample", warn_flag, 1);
        @(negedge clk) begin cw = 1'b0; cr = 1'b0; end
        do_tick(6);
        chk("R7 rst held", rst_req, 1);
        do_tick(2);
        chk("R7 rst released", rst_req, 0);
        chk("R8 flag sticky", warn_flag, 1);
        chk("R8 irq masked", irq, 0);
        do_write(7'h2C);
        chk("R8 irq enabled", irq, 1);
        do_write(7'h6C);
        chk("R8 flag cleared", warn_flag, 0);
        chk("R8 irq cleared", irq, 0);
    endtask

    task automatic t_stop();
        pulse_rst(1'b0);
        do_write(7'h0C);
        @(negedge clk) stop = 1'b1;
        @(negedge clk);
        chk("R3 gated in stop", mon_en, 0);
        @(negedge clk) begin cw = 1'b1; cr = 1'b1; end
        do_tick(20);
        chk("R3 no warn in stop", warn_flag, 0);
        chk("R3 no rst in stop", rst_req, 0);
        @(negedge clk) cp = 1'b1;
        #1 chk("R4 por trip", rst_req, 1);
        @(negedge clk) begin cp = 1'b0; cr = 1'b0; wake = 1'b1; end
        #1 chk("R9 enabled on wake", mon_en, 1);
        do_tick(1);
        chk("R9 not ready mid window", wake_ready, 0);
        do_tick(1);
        chk("R9 ready after sample", wake_ready, 1);
        chk("R9 warn flagged on wake", warn_flag, 1);
        @(negedge clk) begin stop = 1'b0; wake = 1'b0; cw = 1'b0; end
        #1 chk("R9 ready drops", wake_ready, 0);
        do_write(7'h48);                       // stop_dis=0, clear flag
        @(negedge clk) stop = 1'b1;
        #1 chk("R3 monitoring kept in stop", mon_en, 1);
        @(negedge clk) stop = 1'b0;
    endtask

    task automatic t_restart();
        do_write(7'h0C);
        do_tick(4);
        chk("R10 window closed", mon_en, 0);
        do_write(7'h0C);
        chk("R10 restart on write", mon_en, 1);
        do_tick(2);
        chk("R10 restarted period", mon_en, 0);
        pulse_rst(1'b0);
        chk("R10 after rst_n release", mon_en, 1);
        pulse_rst(1'b1);
        chk("R1 thr cleared by por", thr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_period();
        t_sample();
        t_stop();
        t_restart();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule